// File: doc/BRIEF.md
# Persistent Request Arbiter

This block sits beside a memory controller and resolves starvation among processors whose ordinary coherence requests keep failing. A processor that gives up on the normal path files one persistent request naming a block address. The arbiter queues these requests in arrival order and grants exactly one at a time. For each grant it broadcasts an activate message carrying the block address and the winning node. Every node keeps a small table of the active requester, and it fills that table from the broadcast.

The granted request stays in force until its owner reports completion with a deactivate. The arbiter then broadcasts a deactivate for that grant. On the following cycle it broadcasts the activate for the next waiting request, if one is queued. Deactivates that do not come from the current owner change nothing and raise a one-cycle error pulse. A second request from a node that already has one outstanding is dropped in the same way. How tokens move in response to a grant is handled elsewhere.

Top module: `pers_req_arbiter`

## Requirements
- R1: After reset, `bc_valid`, `req_err`, `deact_err` and every `tbl_valid` bit are 0.
- R2: A request accepted at clock edge k while nothing is granted or queued appears as an activate broadcast (`bc_valid`=1, `bc_kind`=1) after edge k+1, carrying the request's node and address.
- R3: Queued requests are granted strictly in the order in which they were accepted.
- R4: At most one grant is open at a time. No activate is broadcast while a grant is open, and a deactivate broadcast always comes before the next activate.
- R5: A deactivate from the owner of the open grant, sampled at edge m, produces a deactivate broadcast (`bc_kind`=0) after edge m, naming the owner and its address. If a request is waiting, its activate follows after edge m+1.
- R6: A deactivate from any other node, or one sent while no grant is open, produces no broadcast and leaves the tables unchanged. It raises `deact_err` for one cycle after the sampling edge.
- R7: A request from a node that already has an outstanding (queued or granted) request is dropped. It raises `req_err` for one cycle after the sampling edge and is never granted.
- R8: Every node table holds valid=1 with the granted address and node one cycle after an activate broadcast. Every table goes back to valid=0 one cycle after the matching deactivate broadcast.
- R9: A deactivate and a new request sampled at the same edge are both handled. The deactivate broadcast comes first and the new request's activate follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Persistent request strobe |
| req_node | input | ID_W | Requesting node |
| req_addr | input | ADDR_W | Requested block address |
| deact_valid | input | 1 | Completion (deactivate) strobe |
| deact_node | input | ID_W | Node sending the deactivate |
| bc_valid | output | 1 | Broadcast message valid (one cycle) |
| bc_kind | output | 1 | 1 = activate, 0 = deactivate |
| bc_node | output | ID_W | Node named by the broadcast |
| bc_addr | output | ADDR_W | Block named by the broadcast |
| req_err | output | 1 | Duplicate request dropped |
| deact_err | output | 1 | Stray deactivate ignored |
| tbl_valid | output | NODES | Per-node table entry valid |
| tbl_addr | output | NODES*ADDR_W | Per-node table addresses, node i at bits i*ADDR_W |
| tbl_node | output | NODES*ID_W | Per-node table requester IDs, node i at bits i*ID_W |

## Verification
An activate is due two edges after its request: one edge to enter the queue and one to leave it as a registered broadcast. The node tables follow one edge after that. A deactivate broadcast and both error pulses are due one edge after their stimulus, and a waiting request's activate comes one edge after the deactivate broadcast. The bench drives inputs on falling edges, advances a counted number of rising edges, and then samples on the next falling edge. Each check therefore lands on exactly the cycle its requirement names.

// File: rtl/pra_pkg.sv
package pra_pkg;
  typedef enum logic {
    BC_DEACT = 1'b0,
    BC_ACT   = 1'b1
  } bc_kind_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_HOLD = 1'b1
  } sq_state_e;
endpackage

// File: rtl/pra_fifo.sv
module pra_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) bump = '0;
    else                     bump = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/pra_sequencer.sv
module pra_sequencer
  import pra_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 16,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [ID_W-1:0]   q_node,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              deact_valid,
  input  logic [ID_W-1:0]   deact_node,
  output logic              q_pop,
  output logic              release_en,
  output logic [ID_W-1:0]   release_node,
  output logic              bc_valid,
  output bc_kind_e          bc_kind,
  output logic [ID_W-1:0]   bc_node,
  output logic [ADDR_W-1:0] bc_addr,
  output logic              deact_err
);
  sq_state_e         state;
  logic [ID_W-1:0]   own_node;
  logic [ADDR_W-1:0] own_addr;
  logic              good_deact;

  assign good_deact   = (state == SQ_HOLD) && deact_valid && (deact_node == own_node);
  assign q_pop        = (state == SQ_IDLE) && !q_empty;
  assign release_en   = good_deact;
  assign release_node = own_node;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      own_node  <= '0;
      own_addr  <= '0;
      bc_valid  <= 1'b0;
      bc_kind   <= BC_DEACT;
      bc_node   <= '0;
      bc_addr   <= '0;
      deact_err <= 1'b0;
    end else begin
      bc_valid  <= 1'b0;
      deact_err <= deact_valid && !good_deact;
      case (state)
        SQ_IDLE: begin
          if (!q_empty) begin
            state    <= SQ_HOLD;
            own_node <= q_node;
            own_addr <= q_addr;
            bc_valid <= 1'b1;
            bc_kind  <= BC_ACT;
            bc_node  <= q_node;
            bc_addr  <= q_addr;
          end
        end
        SQ_HOLD: begin
          if (good_deact) begin
            state    <= SQ_IDLE;
            bc_valid <= 1'b1;
            bc_kind  <= BC_DEACT;
            bc_node  <= own_node;
            bc_addr  <= own_addr;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pra_node_table.sv
module pra_node_table
  import pra_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 16,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bc_valid,
  input  bc_kind_e          bc_kind,
  input  logic [ID_W-1:0]   bc_node,
  input  logic [ADDR_W-1:0] bc_addr,
  output logic              ent_valid,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [ID_W-1:0]   ent_node
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
      ent_addr  <= '0;
      ent_node  <= '0;
    end else if (bc_valid) begin
      if (bc_kind == BC_ACT) begin
        ent_valid <= 1'b1;
        ent_addr  <= bc_addr;
        ent_node  <= bc_node;
      end else if (ent_valid && ent_addr == bc_addr && ent_node == bc_node) begin
        ent_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pers_req_arbiter.sv
module pers_req_arbiter
  import pra_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 16,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ID_W-1:0]         req_node,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    deact_valid,
  input  logic [ID_W-1:0]         deact_node,
  output logic                    bc_valid,
  output logic                    bc_kind,
  output logic [ID_W-1:0]         bc_node,
  output logic [ADDR_W-1:0]       bc_addr,
  output logic                    req_err,
  output logic                    deact_err,
  output logic [NODES-1:0]        tbl_valid,
  output logic [NODES*ADDR_W-1:0] tbl_addr,
  output logic [NODES*ID_W-1:0]   tbl_node
);
  localparam int QW = ID_W + ADDR_W;

  logic [NODES-1:0]  pending;
  logic              accept;
  logic              q_empty, q_pop;
  logic [QW-1:0]     q_head;
  logic              release_en;
  logic [ID_W-1:0]   release_node;
  bc_kind_e          kind_q;

  assign accept = req_valid && !pending[req_node];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      req_err <= 1'b0;
    end else begin
      req_err <= req_valid && pending[req_node];
      for (int i = 0; i < NODES; i++) begin
        if (accept && req_node == ID_W'(i))
          pending[i] <= 1'b1;
        else if (release_en && release_node == ID_W'(i))
          pending[i] <= 1'b0;
      end
    end
  end

  pra_fifo #(.DEPTH(NODES), .W(QW)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   ({req_node, req_addr}),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty)
  );

  pra_sequencer #(.NODES(NODES), .ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .q_empty      (q_empty),
    .q_node       (q_head[QW-1:ADDR_W]),
    .q_addr       (q_head[ADDR_W-1:0]),
    .deact_valid  (deact_valid),
    .deact_node   (deact_node),
    .q_pop        (q_pop),
    .release_en   (release_en),
    .release_node (release_node),
    .bc_valid     (bc_valid),
    .bc_kind      (kind_q),
    .bc_node      (bc_node),
    .bc_addr      (bc_addr),
    .deact_err    (deact_err)
  );

  assign bc_kind = kind_q;

  for (genvar g = 0; g < NODES; g++) begin : g_tbl
    pra_node_table #(.NODES(NODES), .ADDR_W(ADDR_W)) u_tbl (
      .clk       (clk),
      .rst       (rst),
      .bc_valid  (bc_valid),
      .bc_kind   (kind_q),
      .bc_node   (bc_node),
      .bc_addr   (bc_addr),
      .ent_valid (tbl_valid[g]),
      .ent_addr  (tbl_addr[g*ADDR_W +: ADDR_W]),
      .ent_node  (tbl_node[g*ID_W +: ID_W])
    );
  end
endmodule

// File: rtl/pers_req_arbiter_chk.sv
module pers_req_arbiter_chk #(
  parameter int NODES  = 4,
  parameter int ADDR_W = 16,
  localparam int ID_W  = $clog2(NODES)
) (
  input logic               clk,
  input logic               rst,
  input logic               bc_valid,
  input logic               bc_kind,
  input logic [ID_W-1:0]    bc_node,
  input logic               req_err,
  input logic               deact_err,
  input logic [NODES-1:0]   tbl_valid
);
  logic            open_q;
  logic [ID_W-1:0] open_node;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      open_node <= '0;
    end else if (bc_valid) begin
      open_q    <= bc_kind;
      open_node <= bc_node;
    end
  end

  p_single_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_kind) |-> !open_q);

  p_deact_matches_r5: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_kind) |-> (open_q && bc_node == open_node));

  p_stray_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    deact_err |-> !(bc_valid && !bc_kind));

  p_tbl_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_kind) |=> (tbl_valid == {NODES{1'b1}}));

  p_tbl_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_kind) |=> (tbl_valid == '0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!bc_valid && !req_err && !deact_err && tbl_valid == '0));
endmodule

bind pers_req_arbiter pers_req_arbiter_chk #(.NODES(NODES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bc_valid  (bc_valid),
  .bc_kind   (bc_kind),
  .bc_node   (bc_node),
  .req_err   (req_err),
  .deact_err (deact_err),
  .tbl_valid (tbl_valid)
);

// File: tb/test_pers_req_arbiter.sv
`timescale 1ns/1ps
module test_pers_req_arbiter;
  localparam int NODES  = 4;
  localparam int ADDR_W = 16;
  localparam int ID_W   = $clog2(NODES);

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    req_valid;
  logic [ID_W-1:0]         req_node;
  logic [ADDR_W-1:0]       req_addr;
  logic                    deact_valid;
  logic [ID_W-1:0]         deact_node;
  logic                    bc_valid, bc_kind;
  logic [ID_W-1:0]         bc_node;
  logic [ADDR_W-1:0]       bc_addr;
  logic                    req_err, deact_err;
  logic [NODES-1:0]        tbl_valid;
  logic [NODES*ADDR_W-1:0] tbl_addr;
  logic [NODES*ID_W-1:0]   tbl_node;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pers_req_arbiter #(.NODES(NODES), .ADDR_W(ADDR_W)) i_pers_req_arbiter (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_node(req_node), .req_addr(req_addr),
    .deact_valid(deact_valid), .deact_node(deact_node),
    .bc_valid(bc_valid), .bc_kind(bc_kind), .bc_node(bc_node), .bc_addr(bc_addr),
    .req_err(req_err), .deact_err(deact_err),
    .tbl_valid(tbl_valid), .tbl_addr(tbl_addr), .tbl_node(tbl_node)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_bc(input string tag, input bit kind, input int node, input int addr);
    chk(bc_valid == 1'b1, {tag, " valid"}, bc_valid, 1);
    chk(bc_kind == kind, {tag, " kind"}, bc_kind, kind);
    chk(bc_node == ID_W'(node), {tag, " node"}, bc_node, node);
    chk(bc_addr == ADDR_W'(addr), {tag, " addr"}, bc_addr, addr);
  endtask

  task automatic chk_quiet(input string tag);
    chk(bc_valid == 1'b0, {tag, " no broadcast"}, bc_valid, 0);
  endtask

  task automatic chk_tables(input string tag, input bit v, input int node, input int addr);
    for (int i = 0; i < NODES; i++) begin
      chk(tbl_valid[i] == v, {tag, " tbl valid"}, tbl_valid[i], v);
      if (v) begin
        chk(tbl_addr[i*ADDR_W +: ADDR_W] == ADDR_W'(addr), {tag, " tbl addr"},
            tbl_addr[i*ADDR_W +: ADDR_W], addr);
        chk(tbl_node[i*ID_W +: ID_W] == ID_W'(node), {tag, " tbl node"},
            tbl_node[i*ID_W +: ID_W], node);
      end
    end
  endtask

  task automatic drive_req(input int node, input int addr);
    req_valid = 1'b1;
    req_node  = ID_W'(node);
    req_addr  = ADDR_W'(addr);
  endtask

  task automatic drive_deact(input int node);
    deact_valid = 1'b1;
    deact_node  = ID_W'(node);
  endtask

  task automatic idle_inputs();
    req_valid   = 1'b0;
    deact_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(bc_valid == 0, "R1 bc_valid", bc_valid, 0);
    chk(req_err == 0, "R1 req_err", req_err, 0);
    chk(deact_err == 0, "R1 deact_err", deact_err, 0);
    chk(tbl_valid == '0, "R1 tbl_valid", tbl_valid, 0);
  endtask

  task automatic t_single();
    drive_req(2, 'h1234);
    tick(); idle_inputs();
    chk_quiet("R2 early");
    tick();
    chk_bc("R2 activate", 1'b1, 2, 'h1234);
    tick();
    chk_quiet("R4 one pulse");
    chk_tables("R8 fill", 1'b1, 2, 'h1234);
    drive_deact(2);
    tick(); idle_inputs();
    chk_bc("R5 deactivate", 1'b0, 2, 'h1234);
    tick();
    chk_quiet("R5 nothing waiting");
    chk_tables("R8 clear", 1'b0, 0, 0);
  endtask

  task automatic t_order();
    drive_req(1, 'h0A01);
    tick();
    drive_req(3, 'h0B03);
    tick();
    chk_bc("R3 first grant", 1'b1, 1, 'h0A01);
    drive_req(0, 'h0C00);
    tick(); idle_inputs();
    chk_quiet("R4 hold while open");
    chk_tables("R8 first", 1'b1, 1, 'h0A01);
    drive_deact(3);
    tick(); idle_inputs();
    chk(deact_err == 1'b1, "R6 stray deact_err", deact_err, 1);
    chk_quiet("R6 stray ignored");
    tick();
    chk(deact_err == 1'b0, "R6 pulse length", deact_err, 0);
    chk_tables("R6 tables kept", 1'b1, 1, 'h0A01);
    drive_deact(1);
    tick(); idle_inputs();
    chk_bc("R5 deact first", 1'b0, 1, 'h0A01);
    tick();
    chk_bc("R3 second grant", 1'b1, 3, 'h0B03);
    tick();
    chk_tables("R8 second", 1'b1, 3, 'h0B03);
    drive_deact(3);
    tick(); idle_inputs();
    chk_bc("R5 deact second", 1'b0, 3, 'h0B03);
    tick();
    chk_bc("R3 third grant", 1'b1, 0, 'h0C00);
    drive_deact(0);
    tick(); idle_inputs();
    chk_bc("R5 deact third", 1'b0, 0, 'h0C00);
    tick();
    chk_quiet("R3 queue drained");
  endtask

  task automatic t_dup();
    drive_req(0, 'h0111);
    tick();
    drive_req(0, 'h0222);
    tick(); idle_inputs();
    chk(req_err == 1'b1, "R7 req_err", req_err, 1);
    chk_bc("R7 original granted", 1'b1, 0, 'h0111);
    tick();
    chk(req_err == 1'b0, "R7 pulse length", req_err, 0);
    drive_deact(0);
    tick(); idle_inputs();
    chk_bc("R7 deact", 1'b0, 0, 'h0111);
    tick();
    chk_quiet("R7 duplicate never granted");
    tick();
    chk_quiet("R7 still quiet");
    chk_tables("R7 tables empty", 1'b0, 0, 0);
  endtask

  task automatic t_idle_deact();
    drive_deact(2);
    tick(); idle_inputs();
    chk(deact_err == 1'b1, "R6 idle deact_err", deact_err, 1);
    chk_quiet("R6 idle ignored");
  endtask

  task automatic t_concurrent();
    drive_req(1, 'h0F01);
    tick(); idle_inputs();
    tick();
    chk_bc("R9 grant", 1'b1, 1, 'h0F01);
    tick();
    drive_deact(1);
    drive_req(2, 'h0F02);
    tick(); idle_inputs();
    chk_bc("R9 deact first", 1'b0, 1, 'h0F01);
    chk(req_err == 1'b0, "R9 no req_err", req_err, 0);
    tick();
    chk_bc("R9 next grant", 1'b1, 2, 'h0F02);
    tick();
    chk_tables("R9 tables", 1'b1, 2, 'h0F02);
    drive_deact(2);
    tick(); idle_inputs();
    chk_bc("R9 final deact", 1'b0, 2, 'h0F02);
    tick();
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    req_node = '0; req_addr = '0; deact_node = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_dup();
    t_idle_deact();
    t_concurrent();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule